// File: doc/BRIEF.md
# Prioritized ADC Conversion Sequencer

This block decides which of sixteen analog inputs a single converter samples next, and where each result goes. The converter sits outside the block behind a simple handshake. The sequencer pulses `adc_start` with a channel number, waits for `adc_done`, and then stores `{channel, result}` in a result FIFO. There are two kinds of work.

Normal work is a scan over a programmed channel set, or a single-shot conversion of one chosen channel. It is started by one trigger source, chosen from a software pulse, an external pin edge or a timer event. A scan may run once or repeat.

Urgent work is a priority conversion at one of two levels. It is requested through separate request inputs. It is served at the next conversion boundary, ahead of any scan, and its results go to their own, smaller FIFO.

The control is a three-state machine:

- `S_IDLE` picks the next job. Priority level 1 comes first, then level 2, then an active scan, then a pending trigger.
- `S_LAUNCH` drives the one-cycle start pulse.
- `S_WAIT` holds until the converter reports completion.

The transitions are:

- **launch**: `S_IDLE`→`S_LAUNCH` when any job is pending.
- **issue**: `S_LAUNCH`→`S_WAIT`, taken unconditionally.
- **complete**: `S_WAIT`→`S_IDLE` on `adc_done`.

Each FIFO reads in first-word fall-through fashion. The head entry is visible on the data output whenever the empty flag is low, and a read pulse pops it.

Top module: `adc_prio_seq`

## Requirements
- R1: After reset, `adc_start`, `irq_scan`, `irq_pri`, `scan_ovr` and `pri_ovr` are 0, and `scan_empty` and `pri_empty` are 1.
- R2: When `cfg_mode_scan`=0, a trigger converts channel `cfg_single_ch` exactly once, stores one entry and raises `irq_scan` once.
- R3: When `cfg_mode_scan`=1, a trigger converts every channel whose bit is set in `cfg_scan_mask`, once each and in ascending index order. Each result goes to the scan FIFO. `irq_scan` pulses for one cycle after the last result. A trigger with an all-zero mask starts nothing.
- R4: With `cfg_mode_scan`=1 and `cfg_repeat`=1, a finished pass restarts at the lowest set channel. Each pass raises `irq_scan`. Clearing `cfg_repeat` stops the scan at the end of the current pass.
- R5: `cfg_trig_sel` selects the start source:
  - 2'b00 selects `sw_start`.
  - 2'b01 selects a rising edge of `ext_trig`.
  - 2'b10 selects `tmr_evt`.
  - 2'b11 selects nothing.
  Unselected sources have no effect.
- R6: A trigger that arrives while a scan is in progress is ignored. It starts no extra pass.
- R7: A priority request is latched. It is served at the next conversion boundary, before any further scan channel. The conversion in flight is never aborted, and the scan then resumes at its next channel.
- R8: When both priority levels are pending, level 1 (`pri1_*`) is converted before level 2 (`pri2_*`).
- R9: A FIFO entry is 14 bits. Bits 13:10 hold the channel and bits 9:0 hold the result. Scan results go to a 16-entry FIFO, priority results to a 4-entry FIFO, and entries read out in arrival order.
- R10: A write into a full FIFO is discarded, leaving the stored entries unchanged. It also sets that FIFO's overrun flag, which stays set until reset. Filling a FIFO exactly to its depth does not set the flag.
- R11: `irq_pri` pulses once for every completed priority conversion.
- R12: `adc_start` is a one-cycle pulse with `adc_ch` valid. No new start is issued until `adc_done` has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_scan | input | 1 | 1 = scan over mask, 0 = single-shot |
| cfg_repeat | input | 1 | Repeat the scan pass |
| cfg_scan_mask | input | 16 | Channel set for the scan |
| cfg_single_ch | input | 4 | Channel for single-shot |
| cfg_trig_sel | input | 2 | Start source select |
| sw_start | input | 1 | Software start pulse |
| ext_trig | input | 1 | External trigger level (rising edge used) |
| tmr_evt | input | 1 | Timer event pulse |
| pri1_req | input | 1 | Level-1 priority request pulse |
| pri1_ch | input | 4 | Level-1 channel |
| pri2_req | input | 1 | Level-2 priority request pulse |
| pri2_ch | input | 4 | Level-2 channel |
| adc_start | output | 1 | Converter start pulse |
| adc_ch | output | 4 | Channel to convert |
| adc_done | input | 1 | Converter completion pulse |
| adc_result | input | 10 | Converter result, valid with done |
| scan_rd | input | 1 | Pop the scan FIFO |
| scan_rdata | output | 14 | Scan FIFO head entry |
| scan_empty | output | 1 | Scan FIFO empty |
| scan_ovr | output | 1 | Scan FIFO overrun (sticky) |
| pri_rd | input | 1 | Pop the priority FIFO |
| pri_rdata | output | 14 | Priority FIFO head entry |
| pri_empty | output | 1 | Priority FIFO empty |
| pri_ovr | output | 1 | Priority FIFO overrun (sticky) |
| irq_scan | output | 1 | Pass-complete pulse |
| irq_pri | output | 1 | Priority-conversion-complete pulse |

## Verification
The hardest situation to reach from the ports is this: both priority levels become pending in the same cycle while a scan conversion is still in flight. The resulting order must then be checked, with the scan conversion finishing first, then level 1, then level 2, then the next scan channel.

The bench stretches the modelled converter latency to four cycles and watches the stream of start pulses. It injects both requests right after the first scan start, so they land inside that conversion. It then compares the full start sequence and both FIFO contents against lists it builds itself. Random masks and latencies cover the plain scan order around this directed case.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LAUNCH = 2'd1,
        S_WAIT   = 2'd2
    } seq_state_e;

    localparam logic [1:0] TRIG_SW  = 2'b00;
    localparam logic [1:0] TRIG_EXT = 2'b01;
    localparam logic [1:0] TRIG_TMR = 2'b10;
endpackage

// File: rtl/adcseq_trig.sv
module adcseq_trig
    import adcseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       sw,
    input  logic       ext,
    input  logic       tmr,
    output logic       fire
);
    logic ext_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext;
    end

    always_comb begin
        unique case (sel)
            TRIG_SW:  fire = sw;
            TRIG_EXT: fire = ext & ~ext_q;
            TRIG_TMR: fire = tmr;
            default:  fire = 1'b0;
        endcase
    end

    // R5: with no source selected nothing may fire
    assert_none_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11) |-> !fire);
endmodule

// File: rtl/adcseq_fifo.sv
module adcseq_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         ovr
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full, wr_ok, rd_ok;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign wr_ok = wr && !full;
    assign rd_ok = rd && !empty;
    assign rdata = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            ovr <= 1'b0;
        end else begin
            if (wr_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (rd_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            if (wr && full) ovr <= 1'b1;
            cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    // R10: a dropped write raises the overrun flag
    assert_drop_sets_ovr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full) |=> ovr);
    // R10: a dropped write leaves the FIFO full when nothing is read
    assert_full_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full && !rd) |=> full);
    // R9: a pop with no write removes exactly one entry
    assert_pop_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !empty && !wr) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int N_CH  = 16,
    parameter int RES_W = 10,
    localparam int CH_W = $clog2(N_CH),
    localparam int ENT_W = CH_W + RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode_scan,
    input  logic             cfg_repeat,
    input  logic [N_CH-1:0]  cfg_scan_mask,
    input  logic [CH_W-1:0]  cfg_single_ch,
    input  logic             fire,
    input  logic             pri1_req,
    input  logic [CH_W-1:0]  pri1_ch,
    input  logic             pri2_req,
    input  logic [CH_W-1:0]  pri2_ch,
    output logic             adc_start,
    output logic [CH_W-1:0]  adc_ch,
    input  logic             adc_done,
    input  logic [RES_W-1:0] adc_result,
    output logic             scan_wr,
    output logic             pri_wr,
    output logic [ENT_W-1:0] wdata,
    output logic             irq_scan,
    output logic             irq_pri
);
    seq_state_e      state_q, state_d;
    logic            p1_pend, p2_pend, trig_pend, scan_act, cur_pri;
    logic [CH_W-1:0] p1_ch, p2_ch, scan_ptr, cur_ch;
    logic [N_CH-1:0] eff_mask;
    logic [CH_W-1:0] first_ch, nxt_ch;
    logic            has_nxt;

    // channel set of the normal path: the scan mask or the single channel
    always_comb begin
        eff_mask = '0;
        if (cfg_mode_scan) eff_mask = cfg_scan_mask;
        else               eff_mask[cfg_single_ch] = 1'b1;
    end

    // lowest set channel, and lowest set channel above the scan pointer
    always_comb begin
        first_ch = '0;
        nxt_ch   = '0;
        has_nxt  = 1'b0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (eff_mask[i]) first_ch = CH_W'(i);
            if (eff_mask[i] && (i > int'(scan_ptr))) begin
                has_nxt = 1'b1;
                nxt_ch  = CH_W'(i);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (p1_pend || p2_pend || scan_act || trig_pend) state_d = S_LAUNCH;
            S_LAUNCH: state_d = S_WAIT;
            S_WAIT:   if (adc_done) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1_pend   <= 1'b0;
            p2_pend   <= 1'b0;
            p1_ch     <= '0;
            p2_ch     <= '0;
            trig_pend <= 1'b0;
            scan_act  <= 1'b0;
            scan_ptr  <= '0;
            cur_ch    <= '0;
            cur_pri   <= 1'b0;
            irq_scan  <= 1'b0;
            irq_pri   <= 1'b0;
        end else begin
            irq_scan <= 1'b0;
            irq_pri  <= 1'b0;
            if (pri1_req && !p1_pend) begin
                p1_pend <= 1'b1;
                p1_ch   <= pri1_ch;
            end
            if (pri2_req && !p2_pend) begin
                p2_pend <= 1'b1;
                p2_ch   <= pri2_ch;
            end
            if (fire && !scan_act && (eff_mask != '0)) trig_pend <= 1'b1;
            case (state_q)
                S_IDLE: begin
                    if (p1_pend) begin
                        p1_pend <= 1'b0;
                        cur_ch  <= p1_ch;
                        cur_pri <= 1'b1;
                    end else if (p2_pend) begin
                        p2_pend <= 1'b0;
                        cur_ch  <= p2_ch;
                        cur_pri <= 1'b1;
                    end else if (scan_act) begin
                        cur_ch  <= scan_ptr;
                        cur_pri <= 1'b0;
                    end else if (trig_pend) begin
                        trig_pend <= 1'b0;
                        scan_act  <= 1'b1;
                        scan_ptr  <= first_ch;
                        cur_ch    <= first_ch;
                        cur_pri   <= 1'b0;
                    end
                end
                S_WAIT: begin
                    if (adc_done) begin
                        if (cur_pri) begin
                            irq_pri <= 1'b1;
                        end else if (has_nxt) begin
                            scan_ptr <= nxt_ch;
                        end else begin
                            irq_scan <= 1'b1;
                            if (cfg_mode_scan && cfg_repeat) scan_ptr <= first_ch;
                            else                             scan_act <= 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        adc_start = (state_q == S_LAUNCH);
        adc_ch    = cur_ch;
        scan_wr   = (state_q == S_WAIT) && adc_done && !cur_pri;
        pri_wr    = (state_q == S_WAIT) && adc_done && cur_pri;
        wdata     = {cur_ch, adc_result};
    end

    // R12: the start pulse lasts a single cycle
    assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);
    // R7: a pending priority request wins the next launch
    assert_pri_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && (p1_pend || p2_pend)) |=> (adc_start && cur_pri));
    // R8: level 1 is launched before level 2
    assert_lvl_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && p1_pend) |=> (adc_ch == $past(p1_ch)));
    // R3: the pass-complete pulse follows a converter completion
    assert_irq_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_scan |-> $past(adc_done));
    // R11: the two interrupt pulses never coincide
    assert_irq_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_scan && irq_pri));
endmodule

// File: rtl/adc_prio_seq.sv
module adc_prio_seq #(
    parameter int N_CH       = 16,
    parameter int RES_W      = 10,
    parameter int SCAN_DEPTH = 16,
    parameter int PRI_DEPTH  = 4,
    localparam int CH_W      = $clog2(N_CH),
    localparam int ENT_W     = CH_W + RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode_scan,
    input  logic             cfg_repeat,
    input  logic [N_CH-1:0]  cfg_scan_mask,
    input  logic [CH_W-1:0]  cfg_single_ch,
    input  logic [1:0]       cfg_trig_sel,
    input  logic             sw_start,
    input  logic             ext_trig,
    input  logic             tmr_evt,
    input  logic             pri1_req,
    input  logic [CH_W-1:0]  pri1_ch,
    input  logic             pri2_req,
    input  logic [CH_W-1:0]  pri2_ch,
    output logic             adc_start,
    output logic [CH_W-1:0]  adc_ch,
    input  logic             adc_done,
    input  logic [RES_W-1:0] adc_result,
    input  logic             scan_rd,
    output logic [ENT_W-1:0] scan_rdata,
    output logic             scan_empty,
    output logic             scan_ovr,
    input  logic             pri_rd,
    output logic [ENT_W-1:0] pri_rdata,
    output logic             pri_empty,
    output logic             pri_ovr,
    output logic             irq_scan,
    output logic             irq_pri
);
    logic             fire, scan_wr, pri_wr;
    logic [ENT_W-1:0] wdata;

    adcseq_trig u_trig (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (cfg_trig_sel),
        .sw   (sw_start),
        .ext  (ext_trig),
        .tmr  (tmr_evt),
        .fire (fire)
    );

    adcseq_ctrl #(.N_CH(N_CH), .RES_W(RES_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_mode_scan(cfg_mode_scan),
        .cfg_repeat   (cfg_repeat),
        .cfg_scan_mask(cfg_scan_mask),
        .cfg_single_ch(cfg_single_ch),
        .fire         (fire),
        .pri1_req     (pri1_req),
        .pri1_ch      (pri1_ch),
        .pri2_req     (pri2_req),
        .pri2_ch      (pri2_ch),
        .adc_start    (adc_start),
        .adc_ch       (adc_ch),
        .adc_done     (adc_done),
        .adc_result   (adc_result),
        .scan_wr      (scan_wr),
        .pri_wr       (pri_wr),
        .wdata        (wdata),
        .irq_scan     (irq_scan),
        .irq_pri      (irq_pri)
    );

    adcseq_fifo #(.DEPTH(SCAN_DEPTH), .W(ENT_W)) u_scan_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (scan_wr),
        .wdata(wdata),
        .rd   (scan_rd),
        .rdata(scan_rdata),
        .empty(scan_empty),
        .ovr  (scan_ovr)
    );

    adcseq_fifo #(.DEPTH(PRI_DEPTH), .W(ENT_W)) u_pri_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (pri_wr),
        .wdata(wdata),
        .rd   (pri_rd),
        .rdata(pri_rdata),
        .empty(pri_empty),
        .ovr  (pri_ovr)
    );
endmodule

// File: tb/adc_prio_seq_tb.sv
`timescale 1ns/1ps
module adc_prio_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mode_scan = 1'b0, cfg_repeat = 1'b0;
    logic [15:0] cfg_scan_mask = '0;
    logic [3:0]  cfg_single_ch = '0;
    logic [1:0]  cfg_trig_sel = 2'b00;
    logic        sw_start = 1'b0, ext_trig = 1'b0, tmr_evt = 1'b0;
    logic        pri1_req = 1'b0, pri2_req = 1'b0;
    logic [3:0]  pri1_ch = '0, pri2_ch = '0;
    logic        adc_start;
    logic [3:0]  adc_ch;
    logic        adc_done = 1'b0;
    logic [9:0]  adc_result = '0;
    logic        scan_rd = 1'b0, pri_rd = 1'b0;
    logic [13:0] scan_rdata, pri_rdata;
    logic        scan_empty, scan_ovr, pri_empty, pri_ovr, irq_scan, irq_pri;

    int n_vec = 0, n_bad = 0;
    int log_ch [256];
    int n_log = 0, n_irq_s = 0, n_irq_p = 0, busy_viol = 0;
    int lat = 2, salt = 0;
    int got [32];
    int n_got = 0;

    always #4 clk = ~clk;

    adc_prio_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode_scan(cfg_mode_scan), .cfg_repeat(cfg_repeat),
        .cfg_scan_mask(cfg_scan_mask), .cfg_single_ch(cfg_single_ch), .cfg_trig_sel(cfg_trig_sel),
        .sw_start(sw_start), .ext_trig(ext_trig), .tmr_evt(tmr_evt),
        .pri1_req(pri1_req), .pri1_ch(pri1_ch), .pri2_req(pri2_req), .pri2_ch(pri2_ch),
        .adc_start(adc_start), .adc_ch(adc_ch), .adc_done(adc_done), .adc_result(adc_result),
        .scan_rd(scan_rd), .scan_rdata(scan_rdata), .scan_empty(scan_empty), .scan_ovr(scan_ovr),
        .pri_rd(pri_rd), .pri_rdata(pri_rdata), .pri_empty(pri_empty), .pri_ovr(pri_ovr),
        .irq_scan(irq_scan), .irq_pri(irq_pri)
    );

    function automatic int res_of(input int ch);
        return (ch * 67 + salt) & 1023;
    endfunction

    function automatic int entry(input int ch);
        return ch * 1024 + res_of(ch);
    endfunction

    // behavioural converter: done after 'lat' cycles
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && adc_start) begin
                int c;
                c = int'(adc_ch);
                log_ch[n_log % 256] = c;
                n_log++;
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    if (adc_start) busy_viol++;
                end
                adc_done   = 1'b1;
                adc_result = 10'(res_of(c));
                @(negedge clk);
                adc_done = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (irq_scan) n_irq_s++;
            if (irq_pri)  n_irq_p++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        n_log = 0; n_irq_s = 0; n_irq_p = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        clr_counts();
    endtask

    task automatic pulse_sw();
        sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
    endtask

    task automatic pulse_tmr();
        tmr_evt = 1'b1; @(negedge clk); tmr_evt = 1'b0;
    endtask

    task automatic wait_irq_s(input int target);
        int t = 0;
        while (n_irq_s < target && t < 3000) begin @(negedge clk); t++; end
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_log(input int target);
        int t = 0;
        while (n_log < target && t < 3000) begin @(negedge clk); t++; end
    endtask

    task automatic drain_scan();
        n_got = 0;
        while (!scan_empty && n_got < 32) begin
            got[n_got] = int'(scan_rdata);
            n_got++;
            scan_rd = 1'b1; @(negedge clk); scan_rd = 1'b0;
        end
    endtask

    task automatic drain_pri();
        n_got = 0;
        while (!pri_empty && n_got < 32) begin
            got[n_got] = int'(pri_rdata);
            n_got++;
            pri_rd = 1'b1; @(negedge clk); pri_rd = 1'b0;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        check("R1 adc_start", int'(adc_start), 0);
        check("R1 scan_empty", int'(scan_empty), 1);
        check("R1 pri_empty", int'(pri_empty), 1);
        check("R1 ovr flags", int'(scan_ovr) + int'(pri_ovr), 0);
        check("R1 irqs", int'(irq_scan) + int'(irq_pri), 0);

        // R2 single-shot
        cfg_mode_scan = 1'b0; cfg_single_ch = 4'd5; lat = 2; salt = 11;
        pulse_sw();
        wait_irq_s(1);
        repeat (20) @(negedge clk);
        check("R2 conversions", n_log, 1);
        check("R2 channel", log_ch[0], 5);
        check("R2 irq_scan count", n_irq_s, 1);
        drain_scan();
        check("R2 entries", n_got, 1);
        check("R9 single entry", got[0], entry(5));

        // R3 / R9 random scans
        for (int it = 0; it < 8; it++) begin
            logic [15:0] m;
            int pc;
            int idx;
            clr_counts();
            m = 16'($urandom) | (16'd1 << ($urandom % 16));
            lat = 1 + int'($urandom % 4);
            salt = int'($urandom % 1024);
            cfg_mode_scan = 1'b1; cfg_repeat = 1'b0; cfg_scan_mask = m;
            pulse_sw();
            wait_irq_s(1);
            pc = 0;
            for (int b = 0; b < 16; b++) if (m[b]) pc++;
            check("R3 conversion count", n_log, pc);
            check("R3 irq_scan once", n_irq_s, 1);
            drain_scan();
            check("R9 scan entry count", n_got, pc);
            idx = 0;
            for (int b = 0; b < 16; b++) begin
                if (m[b]) begin
                    check("R3 ascending order", log_ch[idx], b);
                    check("R9 scan entry", got[idx], entry(b));
                    idx++;
                end
            end
        end

        // R3 empty mask starts nothing
        clr_counts();
        cfg_scan_mask = 16'h0000;
        pulse_sw();
        repeat (30) @(negedge clk);
        check("R3 empty mask", n_log, 0);

        // R5 trigger source selection
        clr_counts();
        cfg_mode_scan = 1'b0; cfg_single_ch = 4'd7; lat = 2;
        cfg_trig_sel = 2'b01;
        pulse_sw(); pulse_tmr();
        repeat (30) @(negedge clk);
        check("R5 unselected ignored (ext sel)", n_log, 0);
        ext_trig = 1'b1;
        repeat (60) @(negedge clk);
        check("R5 ext edge one conversion", n_log, 1);
        check("R5 ext channel", log_ch[0], 7);
        ext_trig = 1'b0;
        cfg_trig_sel = 2'b10;
        pulse_sw();
        repeat (20) @(negedge clk);
        check("R5 sw ignored (tmr sel)", n_log, 1);
        pulse_tmr();
        repeat (30) @(negedge clk);
        check("R5 timer starts", n_log, 2);
        cfg_trig_sel = 2'b11;
        pulse_sw(); pulse_tmr();
        ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
        repeat (30) @(negedge clk);
        check("R5 no source", n_log, 2);
        drain_scan();
        check("R5 entries", n_got, 2);
        cfg_trig_sel = 2'b00;

        // R6 trigger during scan ignored
        clr_counts();
        cfg_mode_scan = 1'b1; cfg_scan_mask = 16'h00F0; lat = 4;
        pulse_sw();
        wait_log(1);
        pulse_sw();
        wait_irq_s(1);
        repeat (60) @(negedge clk);
        check("R6 conversions", n_log, 4);
        check("R6 single pass", n_irq_s, 1);
        drain_scan();
        check("R6 entries", n_got, 4);

        // R7 / R8 / R11 preemption by both levels during a scan conversion
        begin
            int exp_log [10] = '{0, 14, 12, 1, 2, 3, 8, 9, 10, 11};
            int exp_scan [8] = '{0, 1, 2, 3, 8, 9, 10, 11};
            clr_counts();
            salt = 300;
            cfg_scan_mask = 16'h0F0F; lat = 4;
            pulse_sw();
            wait_log(1);
            pri1_ch = 4'd14; pri2_ch = 4'd12;
            pri1_req = 1'b1; pri2_req = 1'b1;
            @(negedge clk);
            pri1_req = 1'b0; pri2_req = 1'b0;
            wait_irq_s(1);
            check("R7 conversion count", n_log, 10);
            for (int i = 0; i < 10; i++) check("R7/R8 launch order", log_ch[i], exp_log[i]);
            check("R11 irq_pri count", n_irq_p, 2);
            drain_pri();
            check("R9 pri entries", n_got, 2);
            check("R8 level1 first entry", got[0], entry(14));
            check("R8 level2 second entry", got[1], entry(12));
            drain_scan();
            check("R7 scan entries", n_got, 8);
            for (int i = 0; i < 8; i++) check("R7 scan resumes", got[i], entry(exp_scan[i]));
        end

        // R4 repeat
        clr_counts();
        cfg_scan_mask = 16'h0003; cfg_repeat = 1'b1; lat = 2;
        pulse_sw();
        wait_log(5);
        cfg_repeat = 1'b0;
        repeat (100) @(negedge clk);
        check("R4 conversions", n_log, 6);
        check("R4 passes", n_irq_s, 3);
        for (int i = 0; i < 6; i++) check("R4 restart order", log_ch[i], i % 2);
        drain_scan();
        check("R4 entries", n_got, 6);

        // R10 scan FIFO boundary and overrun
        do_reset();
        salt = 55;
        cfg_mode_scan = 1'b1; cfg_scan_mask = 16'hFFFF; lat = 1;
        pulse_sw();
        wait_irq_s(1);
        check("R10 exact fill no overrun", int'(scan_ovr), 0);
        cfg_mode_scan = 1'b0; cfg_single_ch = 4'd3;
        pulse_sw();
        wait_irq_s(2);
        check("R10 scan overrun set", int'(scan_ovr), 1);
        drain_scan();
        check("R10 scan entries kept", n_got, 16);
        for (int i = 0; i < 16; i++) check("R10 content unchanged", got[i], entry(i));
        check("R10 scan overrun sticky", int'(scan_ovr), 1);

        // R10 / R11 priority FIFO overrun
        clr_counts();
        for (int k = 0; k < 5; k++) begin
            pri1_ch = 4'(4 + k);
            pri1_req = 1'b1; @(negedge clk); pri1_req = 1'b0;
            repeat (30) @(negedge clk);
        end
        check("R11 irq_pri per conversion", n_irq_p, 5);
        check("R10 pri overrun set", int'(pri_ovr), 1);
        drain_pri();
        check("R10 pri entries kept", n_got, 4);
        for (int i = 0; i < 4; i++) check("R10 pri content", got[i], entry(4 + i));

        do_reset();
        check("R1 overrun cleared by reset", int'(scan_ovr) + int'(pri_ovr), 0);
        check("R12 no start while busy", busy_viol, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule